// File: doc/BRIEF.md
# Nibble-Loaded Auto-Reload Timer

An 8-bit up-counting timer/counter that sits on the 4-bit register bus of a small microcontroller. Software sets the reload value as two 4-bit pieces. The low piece is stored first. Writing the high piece moves the whole reload value into the counter. When the counter passes its top value it reloads itself from the load register and raises a sticky request flag. Software clears the flag by writing zero to it.

The counting clock comes from one of two places. The first is the internal instruction-clock strobe. The second is an external event pin, which passes through a two-flop synchronizer and a rising-edge detector. A 3-bit mode code selects a prescaler that divides the chosen source before it reaches the counter. The count can be read while it runs. Reading the low nibble also captures the high nibble, so a later read of the high nibble belongs to the same 8-bit value.

Top module: `tmr_nib_reload`

## Requirements
- R1: After reset the count, the load register, the mode code, the source select and the request flag are all zero.
- R2: A write to address 0 stores bus_wdata into bits 3:0 of the load register and leaves the count unchanged.
- R3: A write to address 1 stores bus_wdata into bits 7:4 of the load register. On the same edge it loads the count with {bus_wdata, load bits 3:0} and clears the prescaler.
- R4: Each prescaler tick raises the count by one.
- R5: A tick that arrives while the count is 0xFF loads the count from the load register and sets ovf_req.
- R6: A write to address 2 sets the mode: bit 3 selects the source (0 = cpu_tick, 1 = evt_pin) and bits 2:0 select the ratio. Codes 0 to 6 give a ratio of 2^code and code 7 gives 256. The write clears the prescaler. The source that is not selected has no effect.
- R7: The external pin counts on rising edges only. At ratio 1, a rise that is driven before clock edge k updates the count on edge k+2. A level held high counts once.
- R8: ovf_req is sticky. A write to address 3 with bit 0 = 0 clears it. A write with bit 0 = 1 has no effect. An overflow on the same edge as a clear leaves the flag set.
- R9: bus_rdata shows the following, selected by address: 0 gives the live count bits 3:0, 1 gives the latched high nibble, 2 gives {source, mode}, and 3 gives {000, flag}. A read of address 0 latches the count bits 7:4.
- R10: A write to address 1 takes priority over a tick on the same edge, and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | Internal instruction-clock strobe |
| evt_pin | input | 1 | Asynchronous external event input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble |
| ovf_req | output | 1 | Sticky overflow request flag |

## Verification
The hardest situation to reach is two events landing on the same edge. One case is an overflow meeting a software clear or a high-nibble write. The other is a low-nibble read whose latch races a count increment, especially behind the synchronizer delay or a 256 prescaler.

Directed cases preload the count near 0xFF, or just below a nibble carry, and line the bus access up with a tick in the same cycle. A random phase then mixes pin toggles, strobes, reloads and reads against a cycle model kept in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NIB_W  = 4;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_MODE = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  // terminal prescaler value for a mode code: ratio minus one
  function automatic logic [7:0] ratio_last(input logic [MODE_W-1:0] code);
    if (code == '1) return 8'hFF;
    return (8'd1 << code) - 8'd1;
  endfunction
endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pulse,
  input  logic [MODE_W-1:0] mode,
  output logic              tick
);
  logic [PRE_W-1:0] pre_q, pre_d, last;
  logic             at_last;

  assign last    = PRE_W'(ratio_last(mode));
  assign at_last = (pre_q == last);
  assign tick    = pulse & ~clr & at_last;

  always_comb begin
    pre_d = pre_q;
    if (clr)        pre_d = '0;
    else if (pulse) pre_d = at_last ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int NIB_W = 4,
  localparam int CNT_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [NIB_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] load,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d, load_q, load_d;
  logic             flag_q, flag_d, wrap;

  assign wrap = tick & ~hi_we & (cnt_q == '1);

  always_comb begin
    load_d = load_q;
    if (lo_we) load_d[NIB_W-1:0]     = wdata;
    if (hi_we) load_d[CNT_W-1:NIB_W] = wdata;

    cnt_d = cnt_q;
    if (hi_we)     cnt_d = {wdata, load_q[NIB_W-1:0]};
    else if (wrap) cnt_d = load_q;
    else if (tick) cnt_d = cnt_q + 1'b1;

    flag_d = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
      flag_q <= flag_d;
    end
  end

  assign count = cnt_q;
  assign load  = load_q;
  assign flag  = flag_q;
endmodule

// File: rtl/tmr_nib_reload.sv
module tmr_nib_reload
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_tick,
  input  logic             evt_pin,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [NIB_W-1:0] bus_wdata,
  output logic [NIB_W-1:0] bus_rdata,
  output logic             ovf_req
);
  localparam int CNT_W = 2 * NIB_W;

  logic              lo_we, hi_we, mode_we, flag_clr, lo_rd;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              src_q, src_d;
  logic [NIB_W-1:0]  hold_q, hold_d;
  logic              evt_rise, src_pulse, pre_tick;
  logic [CNT_W-1:0]  cnt_q, load_q;

  assign lo_we    = bus_wr & (bus_addr == REG_LO);
  assign hi_we    = bus_wr & (bus_addr == REG_HI);
  assign mode_we  = bus_wr & (bus_addr == REG_MODE);
  assign flag_clr = bus_wr & (bus_addr == REG_FLAG) & ~bus_wdata[0];
  assign lo_rd    = bus_rd & (bus_addr == REG_LO);

  tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin), .rise(evt_rise)
  );

  assign src_pulse = src_q ? evt_rise : cpu_tick;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(hi_we | mode_we),
    .pulse(src_pulse), .mode(mode_q), .tick(pre_tick)
  );

  tmr_core #(.NIB_W(NIB_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .lo_we(lo_we),
    .hi_we(hi_we), .wdata(bus_wdata), .flag_clr(flag_clr),
    .count(cnt_q), .load(load_q), .flag(ovf_req)
  );

  always_comb begin
    mode_d = mode_q;
    src_d  = src_q;
    if (mode_we) begin
      mode_d = bus_wdata[MODE_W-1:0];
      src_d  = bus_wdata[NIB_W-1];
    end
    hold_d = lo_rd ? cnt_q[CNT_W-1:NIB_W] : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      src_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      mode_q <= mode_d;
      src_q  <= src_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_LO:   bus_rdata = cnt_q[NIB_W-1:0];
      REG_HI:   bus_rdata = hold_q;
      REG_MODE: bus_rdata = NIB_W'({src_q, mode_q});
      default:  bus_rdata = NIB_W'(ovf_req);
    endcase
  end
endmodule

// File: rtl/tmr_nib_reload_chk.sv
module tmr_nib_reload_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [3:0] bus_wdata,
  input logic       tick,
  input logic [7:0] count,
  input logic [7:0] load,
  input logic       flag
);
  logic hi_w, clr_w;
  assign hi_w  = bus_wr && bus_addr == 2'd1;
  assign clr_w = bus_wr && bus_addr == 2'd3 && !bus_wdata[0];

  // R3
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_w |=> count == {$past(bus_wdata), $past(load[3:0])});
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == 8'hFF && !hi_w) |=> (count == $past(load) && flag));
  // R4
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != 8'hFF && !hi_w) |=> count == $past(count) + 8'd1);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hi_w) |=> $stable(count));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_w) |=> flag);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !(tick && count == 8'hFF && !hi_w)) |=> !flag);
endmodule

bind tmr_nib_reload tmr_nib_reload_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tick(pre_tick), .count(cnt_q),
  .load(load_q), .flag(ovf_req)
);

// File: tb/tmr_nib_reload_tb.sv
`timescale 1ns/1ps
module tmr_nib_reload_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_tick = 1'b0, evt_pin = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic ovf_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_nib_reload u_dut (.*);

  // reference model, updated on the same edges as the design
  logic [7:0] m_cnt, m_load;
  logic [2:0] m_mode, m_sync;
  logic       m_src, m_flag;
  logic [3:0] m_hold;
  int         m_pre;

  function automatic int ratio(input logic [2:0] c);
    return (c == 3'd7) ? 256 : (1 << c);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_load <= 0; m_mode <= 0; m_sync <= 0;
      m_src <= 0; m_flag <= 0; m_hold <= 0; m_pre <= 0;
    end else begin
      logic pulse, tk, hw, mw;
      pulse = m_src ? (m_sync[1] & ~m_sync[2]) : cpu_tick;
      hw = bus_wr && bus_addr == 2'd1;
      mw = bus_wr && bus_addr == 2'd2;
      tk = 0;
      m_sync <= {m_sync[1:0], evt_pin};
      if (hw || mw) m_pre <= 0;
      else if (pulse) begin
        if (m_pre == ratio(m_mode) - 1) begin m_pre <= 0; tk = 1; end
        else m_pre <= m_pre + 1;
      end
      if (bus_wr && bus_addr == 2'd0) m_load[3:0] <= bus_wdata;
      if (hw) begin m_load[7:4] <= bus_wdata; m_cnt <= {bus_wdata, m_load[3:0]}; end
      else if (tk) m_cnt <= (m_cnt == 8'hFF) ? m_load : m_cnt + 1;
      if (tk && !hw && m_cnt == 8'hFF) m_flag <= 1;
      else if (bus_wr && bus_addr == 2'd3 && !bus_wdata[0]) m_flag <= 0;
      if (mw) begin m_mode <= bus_wdata[2:0]; m_src <= bus_wdata[3]; end
      if (bus_rd && bus_addr == 2'd0) m_hold <= m_cnt[7:4];
    end
  end

  function automatic logic [3:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt[3:0];
      2'd1: return m_hold;
      2'd2: return {m_src, m_mode};
      default: return {3'b000, m_flag};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // one bus cycle; a read compares against the model and returns the data
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [3:0] wd, input logic tk, input logic pin,
                     output logic [3:0] rd_val);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    cpu_tick = tk; evt_pin = pin;
    #1;
    rd_val = bus_rdata;
    if (rd) begin
      chk("R9 readback vs model", {4'h0, bus_rdata}, {4'h0, exp_rd(a)});
      chk("R8 ovf_req vs model", {7'h0, ovf_req}, {7'h0, m_flag});
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d, input logic tk = 0);
    logic [3:0] v; cyc(1, 0, a, d, tk, evt_pin, v);
  endtask
  task automatic rd(input logic [1:0] a, output logic [3:0] v);
    cyc(0, 1, a, 4'h0, 0, evt_pin, v);
  endtask
  task automatic idle(input logic tk, input logic pin);
    logic [3:0] v; cyc(0, 0, 2'd0, 4'h0, tk, pin, v);
  endtask

  initial begin
    logic [3:0] v;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reset value", {4'h0, v}, 8'h00); end
    // R2: low write leaves count alone
    wr(0, 4'hD); rd(0, v); chk("R2 count unchanged", {4'h0, v}, 8'h00);
    // R3: high write transfers load
    wr(1, 4'hF); rd(0, v); chk("R3 low after load", {4'h0, v}, 8'h0D);
    rd(1, v); chk("R3 high after load", {4'h0, v}, 8'h0F);
    // R4/R5: FD -> FE -> FF -> reload FD with flag
    idle(1, 0); idle(1, 0); rd(0, v); chk("R4 count FF low", {4'h0, v}, 8'h0F);
    idle(1, 0); rd(0, v); chk("R5 reload low", {4'h0, v}, 8'h0D);
    chk("R5 flag set", {7'h0, ovf_req}, 8'h01);
    // R8: write 1 no effect, write 0 clears
    wr(3, 4'h1); rd(3, v); chk("R8 write one keeps flag", {4'h0, v}, 8'h01);
    wr(3, 4'h0); rd(3, v); chk("R8 clear", {4'h0, v}, 8'h00);
    // R6: ratio 256
    wr(2, 4'h7); rd(2, v); chk("R6 mode readback", {4'h0, v}, 8'h07);
    wr(0, 4'h0); wr(1, 4'h0);
    repeat (255) idle(1, 0);
    rd(0, v); chk("R6 no tick before 256", {4'h0, v}, 8'h00);
    idle(1, 0); rd(0, v); chk("R6 tick at 256", {4'h0, v}, 8'h01);
    // R7: external source, cpu_tick held high must be ignored (R6)
    wr(2, 4'h8);
    cyc(0, 0, 0, 0, 1, 1, v);
    cyc(0, 1, 0, 0, 1, 1, v); chk("R7 latency edge k", {4'h0, v}, 8'h01);
    cyc(0, 1, 0, 0, 1, 1, v); chk("R7 latency edge k+1", {4'h0, v}, 8'h01);
    cyc(0, 1, 0, 0, 1, 1, v); chk("R7 count on edge k+2", {4'h0, v}, 8'h02);
    repeat (10) idle(1, 1);
    rd(0, v); chk("R7 level counts once", {4'h0, v}, 8'h02);
    // R10: high write beats tick
    wr(2, 4'h0); wr(0, 4'h0); wr(1, 4'h5, 1);
    rd(0, v); chk("R10 write wins low", {4'h0, v}, 8'h00);
    rd(1, v); chk("R10 write wins high", {4'h0, v}, 8'h05);
    // R9: latch taken with low read, tick carries after
    wr(0, 4'hF); wr(1, 4'h0);
    cyc(0, 1, 0, 0, 1, 0, v); chk("R9 live low", {4'h0, v}, 8'h0F);
    rd(1, v); chk("R9 latched high", {4'h0, v}, 8'h00);
    // R8: overflow beats clear
    wr(3, 4'h0); wr(0, 4'hF); wr(1, 4'hF);
    wr(3, 4'h0, 1); rd(3, v); chk("R8 set beats clear", {4'h0, v}, 8'h01);
    // random phase, R4 R5 R6 R7 R8 R9 checked against the model
    for (int i = 0; i < 6000; i++) begin
      int op; logic tk, pin;
      op = $urandom_range(0, 99);
      tk = $urandom_range(0, 1);
      pin = ($urandom_range(0, 3) == 0) ? ~evt_pin : evt_pin;
      if (op < 4)       cyc(1, 0, 2'd2, {1'($urandom_range(0,1)), 3'($urandom_range(0,2))}, tk, pin, v);
      else if (op < 8)  cyc(1, 0, 2'($urandom_range(0,1)), 4'($urandom_range(12,15)), tk, pin, v);
      else if (op < 10) cyc(1, 0, 2'd3, 4'($urandom), tk, pin, v);
      else if (op < 40) cyc(0, 1, 2'($urandom), 4'h0, tk, pin, v);
      else              cyc(0, 0, 2'd0, 4'h0, tk, pin, v);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule